// File: doc/BRIEF.md
# Byte-Bus Load/Store Sequencer Core

This block is a small execution core for the data-movement part of an 8-bit accumulator machine whose byte registers also pair into 16-bit registers. It fetches opcodes from a byte-wide synchronous memory, steps each instruction through one or more machine cycles, and carries out register moves, indirect loads, 16-bit immediate loads, HL auto-increment and auto-decrement transfers, and a store of the stack pointer to an absolute address. Each machine cycle starts at most one memory access. A read started in one cycle returns its byte on `mem_rdata_i` in the next cycle.

Opcode fetch overlaps execution. When the last cycle of an instruction leaves the bus unused, the same cycle issues the read of the next opcode. The returned byte is decoded and its first step runs in the following cycle. A run of register moves therefore retires one instruction per cycle. An opcode outside the supported set stops the core until reset.

Top module: `ldseq_core`

## Requirements
- R1: No cycle asserts both `mem_re_o` and `mem_we_o`. The byte for a read issued in cycle N is taken from `mem_rdata_i` in cycle N+1.
- R2: Reset clears A, B, C, D, E, H, L, SP and PC to zero. In the first cycle after reset the core issues a read at address 0 and does not write.
- R3: When the completing cycle of an instruction makes no access, the read of the next opcode at the new PC is issued in that same cycle. Otherwise it is issued in the next cycle. `retire_o` is high for exactly the completing cycle. The bus is idle in a cycle only when that cycle decodes an unsupported opcode.
- R4: PC advances only on completion: by 3 for opcodes 0x01, 0x11, 0x21, 0x31 and 0x08, and by 1 for all other supported opcodes.
- R5: Opcodes 0x40–0x7F whose bits 5:3 are not 6 copy the register selected by bits 2:0 into the register selected by bits 5:3. The codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7. Such a move completes in its first cycle.
- R6: In that range, a source code of 6 loads the destination from memory at HL. The read is issued in the first cycle and the instruction completes in the second.
- R7: 0x0A loads A from memory at BC and 0x1A loads A from memory at DE, each in two cycles. The pairs are B:C and D:E, with the first-named register as the high byte.
- R8: 0x01, 0x11, 0x21 and 0x31 load BC, DE, HL and SP. The core reads PC+1 into the low byte in cycle 1, reads PC+2 into the high byte in cycle 2, and completes in cycle 3.
- R9: 0x22 and 0x32 write A to memory at HL. 0x2A and 0x3A read memory at HL into A. Each completes on the next cycle with HL changed by +1 (0x22, 0x2A) or −1 (0x32, 0x3A), wrapping modulo 2^16.
- R10: 0x08 reads an address low byte from PC+1 and the high byte from PC+2. It then writes SP[7:0] to that address and, in the next cycle, SP[15:8] to the address plus one (modulo 2^16), completing on the second write.
- R11: Any other opcode, including 0x70–0x77 and 0x02, makes the core issue no access in the decoding cycle. `illegal_o` rises on the next cycle and stays high. There is then no bus access and no retirement until reset, and reset clears `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Address of the access in this cycle |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe; data returns next cycle |
| mem_rdata_i | input | 8 | Read data for the previous cycle's read |
| retire_o | output | 1 | Instruction completes this cycle |
| illegal_o | output | 1 | Sticky unsupported-opcode flag |

## Verification
The bench records the bus cycle by cycle. It targets the cycle in which the next opcode is fetched: a core that never overlapped the fetch would lose a cycle after every move, and a core that overlapped it after a store would put two accesses in one cycle. HL arithmetic is pushed across 0x0000/0xFFFF in both directions, and the SP store is aimed at 0xFFFF, so a carry lost in the 16-bit adders shows up as a wrong write address. Several unsupported opcodes are fed in, including the gap at 0x70–0x77, to catch a decoder that lets them fall into the move group or a core that keeps fetching after the fault.

// File: rtl/ldseq_pkg.sv
`timescale 1ns/1ps
package ldseq_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int NSLOT = 8;

  // register slot codes, equal to the opcode's 3-bit register fields
  localparam logic [2:0] SLOT_H   = 3'd4;
  localparam logic [2:0] SLOT_L   = 3'd5;
  localparam logic [2:0] SLOT_MEM = 3'd6;
  localparam logic [2:0] SLOT_A   = 3'd7;

  typedef enum logic [2:0] {
    K_MOVE, K_LD_IND, K_LD_PAIR, K_IMM16, K_ST_HLX, K_LD_HLX, K_ST_SP, K_BAD
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [2:0] dst;
    logic [2:0] src;
    logic [1:0] pair;     // 0 BC, 1 DE, 2 HL, 3 SP
    logic       hl_down;
    logic [1:0] len;
  } op_info_t;
endpackage

// File: rtl/ldseq_decode.sv
`timescale 1ns/1ps
module ldseq_decode
  import ldseq_pkg::*;
(
  input  logic [DW-1:0] op_i,
  output op_info_t      info_o
);
  always_comb begin
    info_o.kind    = K_BAD;
    info_o.dst     = op_i[5:3];
    info_o.src     = op_i[2:0];
    info_o.pair    = op_i[5:4];
    info_o.hl_down = op_i[4];
    info_o.len     = 2'd1;
    if (op_i[7:6] == 2'b01) begin
      if (op_i[5:3] != SLOT_MEM) begin
        info_o.kind = (op_i[2:0] == SLOT_MEM) ? K_LD_IND : K_MOVE;
      end
    end else if (op_i[7:6] == 2'b00) begin
      unique case (op_i[3:0])
        4'h1: begin
          info_o.kind = K_IMM16;
          info_o.len  = 2'd3;
        end
        4'hA: info_o.kind = op_i[5] ? K_LD_HLX : K_LD_PAIR;
        4'h2: if (op_i[5]) info_o.kind = K_ST_HLX;
        4'h8: if (op_i[5:4] == 2'b00) begin
          info_o.kind = K_ST_SP;
          info_o.len  = 2'd3;
        end
        default: info_o.kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/ldseq_regfile.sv
`timescale 1ns/1ps
module ldseq_regfile
  import ldseq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_we_i,
  input  logic [2:0]    byte_sel_i,
  input  logic [DW-1:0] byte_data_i,
  input  logic          hl_we_i,
  input  logic [AW-1:0] hl_data_i,
  input  logic          sp_lo_we_i,
  input  logic          sp_hi_we_i,
  input  logic [DW-1:0] sp_data_i,
  input  logic [2:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] a_o,
  output logic [AW-1:0] bc_o,
  output logic [AW-1:0] de_o,
  output logic [AW-1:0] hl_o,
  output logic [AW-1:0] sp_o
);
  logic [NSLOT*DW-1:0] bank;
  logic [AW-1:0]       sp_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == int'(SLOT_MEM)) begin : g_hole
      assign bank[g*DW +: DW] = '0;
    end else begin : g_reg
      localparam bit IS_HL = (g == int'(SLOT_H)) || (g == int'(SLOT_L));
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else if (IS_HL && hl_we_i) begin
          q <= (g == int'(SLOT_H)) ? hl_data_i[AW-1:DW] : hl_data_i[DW-1:0];
        end else if (byte_we_i && byte_sel_i == 3'(g)) begin
          q <= byte_data_i;
        end
      end
      assign bank[g*DW +: DW] = q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else begin
      if (sp_lo_we_i) sp_q[DW-1:0]  <= sp_data_i;
      if (sp_hi_we_i) sp_q[AW-1:DW] <= sp_data_i;
    end
  end

  assign rd_data_o = bank[rd_sel_i*DW +: DW];
  assign a_o  = bank[int'(SLOT_A)*DW +: DW];
  assign bc_o = {bank[0*DW +: DW], bank[1*DW +: DW]};
  assign de_o = {bank[2*DW +: DW], bank[3*DW +: DW]};
  assign hl_o = {bank[int'(SLOT_H)*DW +: DW], bank[int'(SLOT_L)*DW +: DW]};
  assign sp_o = sp_q;
endmodule

// File: rtl/ldseq_seq.sv
`timescale 1ns/1ps
module ldseq_seq
  import ldseq_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] mem_rdata_i,
  input  op_info_t      info_i,
  output logic [DW-1:0] cur_op_o,
  input  logic [DW-1:0] a_i,
  input  logic [AW-1:0] bc_i,
  input  logic [AW-1:0] de_i,
  input  logic [AW-1:0] hl_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [2:0]    rd_sel_o,
  output logic          byte_we_o,
  output logic [2:0]    byte_sel_o,
  output logic [DW-1:0] byte_data_o,
  output logic          hl_we_o,
  output logic [AW-1:0] hl_data_o,
  output logic          sp_lo_we_o,
  output logic          sp_hi_we_o,
  output logic [DW-1:0] sp_data_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic          retire_o,
  output logic          illegal_o
);
  logic [DW-1:0] op_q;
  logic          op_vld_q, fetch_q, illegal_q;
  logic [1:0]    step_q;
  logic [AW-1:0] pc_q, hold_q, hold_d;

  logic          active, done, bad, ins_re, ins_we, fetch_now;
  logic [1:0]    step;
  logic [AW-1:0] ins_addr, next_pc;
  logic [DW-1:0] ins_wdata;

  // opcode comes straight off the bus in the cycle after its fetch
  assign cur_op_o = fetch_q ? mem_rdata_i : op_q;
  assign active   = fetch_q | op_vld_q;
  assign step     = fetch_q ? 2'd0 : step_q;
  assign rd_sel_o = info_i.src;
  assign next_pc  = pc_q + AW'(info_i.len);

  always_comb begin
    done        = 1'b0;
    bad         = 1'b0;
    ins_re      = 1'b0;
    ins_we      = 1'b0;
    ins_addr    = hl_i;
    ins_wdata   = '0;
    byte_we_o   = 1'b0;
    byte_sel_o  = info_i.dst;
    byte_data_o = mem_rdata_i;
    hl_we_o     = 1'b0;
    hl_data_o   = info_i.hl_down ? hl_i - AW'(1) : hl_i + AW'(1);
    sp_lo_we_o  = 1'b0;
    sp_hi_we_o  = 1'b0;
    sp_data_o   = mem_rdata_i;
    hold_d      = hold_q;
    if (active && !illegal_q) begin
      unique case (info_i.kind)
        K_MOVE: begin
          byte_we_o   = 1'b1;
          byte_data_o = rd_data_i;
          done        = 1'b1;
        end
        K_LD_IND: begin
          if (step == 2'd0) begin
            ins_re = 1'b1;
          end else begin
            byte_we_o = 1'b1;
            done      = 1'b1;
          end
        end
        K_LD_PAIR: begin
          if (step == 2'd0) begin
            ins_re   = 1'b1;
            ins_addr = info_i.pair[0] ? de_i : bc_i;
          end else begin
            byte_we_o  = 1'b1;
            byte_sel_o = SLOT_A;
            done       = 1'b1;
          end
        end
        K_IMM16: begin
          if (step != 2'd2) begin
            ins_re   = 1'b1;
            ins_addr = pc_q + ((step == 2'd0) ? AW'(1) : AW'(2));
          end
          if (step != 2'd0) begin
            if (info_i.pair == 2'd3) begin
              sp_lo_we_o = (step == 2'd1);
              sp_hi_we_o = (step == 2'd2);
            end else begin
              byte_we_o  = 1'b1;
              byte_sel_o = {info_i.pair, step == 2'd1};
            end
          end
          done = (step == 2'd2);
        end
        K_ST_HLX: begin
          if (step == 2'd0) begin
            ins_we    = 1'b1;
            ins_wdata = a_i;
          end else begin
            hl_we_o = 1'b1;
            done    = 1'b1;
          end
        end
        K_LD_HLX: begin
          if (step == 2'd0) begin
            ins_re = 1'b1;
          end else begin
            byte_we_o  = 1'b1;
            byte_sel_o = SLOT_A;
            hl_we_o    = 1'b1;
            done       = 1'b1;
          end
        end
        K_ST_SP: begin
          unique case (step)
            2'd0: begin
              ins_re   = 1'b1;
              ins_addr = pc_q + AW'(1);
            end
            2'd1: begin
              hold_d   = {{(AW-DW){1'b0}}, mem_rdata_i};
              ins_re   = 1'b1;
              ins_addr = pc_q + AW'(2);
            end
            2'd2: begin
              hold_d    = {mem_rdata_i, hold_q[DW-1:0]};
              ins_we    = 1'b1;
              ins_addr  = {mem_rdata_i, hold_q[DW-1:0]};
              ins_wdata = sp_i[DW-1:0];
            end
            default: begin
              ins_we    = 1'b1;
              ins_addr  = hold_q + AW'(1);
              ins_wdata = sp_i[AW-1:DW];
              done      = 1'b1;
            end
          endcase
        end
        default: bad = 1'b1;
      endcase
    end
  end

  assign fetch_now   = !illegal_q && (!active || (done && !ins_re && !ins_we));
  assign mem_re_o    = ins_re | fetch_now;
  assign mem_we_o    = ins_we;
  assign mem_wdata_o = ins_wdata;
  assign mem_addr_o  = fetch_now ? (active ? next_pc : pc_q) : ins_addr;
  assign retire_o    = done;
  assign illegal_o   = illegal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= '0;
      op_vld_q  <= 1'b0;
      fetch_q   <= 1'b0;
      illegal_q <= 1'b0;
      step_q    <= '0;
      pc_q      <= RESET_PC;
      hold_q    <= '0;
    end else begin
      hold_q <= hold_d;
      if (bad) begin
        illegal_q <= 1'b1;
        fetch_q   <= 1'b0;
        op_vld_q  <= 1'b0;
      end else if (!illegal_q) begin
        if (!active) begin
          fetch_q <= 1'b1;
        end else if (done) begin
          pc_q     <= next_pc;
          op_vld_q <= 1'b0;
          step_q   <= '0;
          fetch_q  <= fetch_now;
        end else begin
          op_q     <= cur_op_o;
          op_vld_q <= 1'b1;
          step_q   <= step + 2'd1;
          fetch_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ldseq_core.sv
`timescale 1ns/1ps
module ldseq_core
  import ldseq_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          retire_o,
  output logic          illegal_o
);
  op_info_t      info;
  logic [DW-1:0] cur_op, a, rd_data, byte_data, sp_data;
  logic [AW-1:0] bc, de, hl, sp, hl_data;
  logic [2:0]    rd_sel, byte_sel;
  logic          byte_we, hl_we, sp_lo_we, sp_hi_we;

  ldseq_decode u_dec (
    .op_i   (cur_op),
    .info_o (info)
  );

  ldseq_regfile u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_we_i   (byte_we),
    .byte_sel_i  (byte_sel),
    .byte_data_i (byte_data),
    .hl_we_i     (hl_we),
    .hl_data_i   (hl_data),
    .sp_lo_we_i  (sp_lo_we),
    .sp_hi_we_i  (sp_hi_we),
    .sp_data_i   (sp_data),
    .rd_sel_i    (rd_sel),
    .rd_data_o   (rd_data),
    .a_o         (a),
    .bc_o        (bc),
    .de_o        (de),
    .hl_o        (hl),
    .sp_o        (sp)
  );

  ldseq_seq #(.RESET_PC(RESET_PC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_rdata_i (mem_rdata_i),
    .info_i      (info),
    .cur_op_o    (cur_op),
    .a_i         (a),
    .bc_i        (bc),
    .de_i        (de),
    .hl_i        (hl),
    .sp_i        (sp),
    .rd_data_i   (rd_data),
    .rd_sel_o    (rd_sel),
    .byte_we_o   (byte_we),
    .byte_sel_o  (byte_sel),
    .byte_data_o (byte_data),
    .hl_we_o     (hl_we),
    .hl_data_o   (hl_data),
    .sp_lo_we_o  (sp_lo_we),
    .sp_hi_we_o  (sp_hi_we),
    .sp_data_o   (sp_data),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .retire_o    (retire_o),
    .illegal_o   (illegal_o)
  );
endmodule

// File: rtl/ldseq_core_chk.sv
`timescale 1ns/1ps
module ldseq_core_chk
  import ldseq_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic          retire_o,
  input logic          illegal_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_one_access_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_boot_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (mem_re_o && !mem_we_o && mem_addr_o == RESET_PC));

  // idle bus only in the cycle that decodes a bad opcode
  assert_idle_means_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_re_o && !mem_we_o) |=> illegal_o);

  assert_sp_pair_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) + AW'(1));

  assert_fault_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);

  assert_fault_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!mem_re_o && !mem_we_o && !retire_o));
endmodule

bind ldseq_core ldseq_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .retire_o   (retire_o),
  .illegal_o  (illegal_o)
);

// File: tb/ldseq_core_test.sv
`timescale 1ns/1ps
module ldseq_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        mem_we_o, mem_re_o, retire_o, illegal_o;

  logic [7:0]  mem [256];
  logic [15:0] log_a [64];
  logic [7:0]  log_d [64];
  int          log_n;
  logic        tr_re [64], tr_we [64], tr_ret [64], tr_ill [64];
  logic [15:0] tr_addr [64];
  int          tc;
  bit          tracing = 1'b0;
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  ldseq_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
    .retire_o(retire_o), .illegal_o(illegal_o)
  );

  // synchronous byte memory, 256 bytes aliased over the address space
  always @(posedge clk) begin
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    if (mem_we_o && rst_ni) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o;
      if (log_n < 64) begin
        log_a[log_n] <= mem_addr_o;
        log_d[log_n] <= mem_wdata_o;
      end
      log_n <= log_n + 1;
    end
  end

  always @(negedge clk) begin
    if (tracing && tc < 64) begin
      tr_re[tc]   = mem_re_o;
      tr_we[tc]   = mem_we_o;
      tr_addr[tc] = mem_addr_o;
      tr_ret[tc]  = retire_o;
      tr_ill[tc]  = illegal_o;
      tc++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_bus(input string tag, input int c, input logic re, input logic we,
                         input logic [15:0] addr);
    chk({tag, " re"}, 32'(tr_re[c]), 32'(re));
    chk({tag, " we"}, 32'(tr_we[c]), 32'(we));
    if (re || we) chk({tag, " addr"}, 32'(tr_addr[c]), 32'(addr));
  endtask

  task automatic chk_log(input string tag, input int i, input logic [15:0] a, input logic [7:0] d);
    chk({tag, " waddr"}, 32'(log_a[i]), 32'(a));
    chk({tag, " wdata"}, 32'(log_d[i]), 32'(d));
  endtask

  task automatic hold_reset();
    tracing = 1'b0;
    rst_ni  = 1'b0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    log_n = 0;
    tc    = 0;
  endtask

  task automatic run(input int n);
    @(posedge clk);
    #1 rst_ni = 1'b1;
    tracing = 1'b1;
    repeat (n) @(posedge clk);
    #1 tracing = 1'b0;
  endtask

  task automatic load(input logic [7:0] prog [], input int base);
    foreach (prog[i]) mem[base + i] = prog[i];
  endtask

  // moves, 16-bit immediates, store through HL+
  task automatic test_moves_and_fetch();
    logic [7:0] p [] = '{8'h21, 8'h80, 8'h00, 8'h11, 8'hCD, 8'hAB, 8'h7A, 8'h22,
                         8'h7B, 8'h22, 8'h00};
    hold_reset();
    load(p, 0);
    run(24);
    chk_bus("R2 boot fetch", 0, 1, 0, 16'h0000);
    chk_bus("R8 imm low read", 1, 1, 0, 16'h0001);
    chk_bus("R8 imm high read", 2, 1, 0, 16'h0002);
    chk_bus("R3 overlapped fetch after imm", 3, 1, 0, 16'h0003);
    chk("R3 retire on imm completion", 32'(tr_ret[3]), 1);
    chk("R3 no retire mid-instruction", 32'(tr_ret[2]), 0);
    chk_bus("R5 move one cycle", 7, 1, 0, 16'h0007);
    chk("R5 move retires", 32'(tr_ret[7]), 1);
    chk_bus("R9 store at HL", 8, 0, 1, 16'h0080);
    chk_bus("R4 pc+1 after store", 9, 1, 0, 16'h0008);
    chk_log("R5 R8 ld a,d", 0, 16'h0080, 8'hAB);
    chk_log("R9 HL incremented", 1, 16'h0081, 8'hCD);
    chk_bus("R11 bad opcode cycle idle", 13, 0, 0, 16'h0000);
    chk("R11 flag before", 32'(tr_ill[13]), 0);
    chk("R11 flag raised", 32'(tr_ill[14]), 1);
    chk_bus("R11 halted", 20, 0, 0, 16'h0000);
    chk("R11 flag holds", 32'(tr_ill[23]), 1);
    chk("R11 no extra writes", log_n, 2);
  endtask

  // indirect loads via BC/DE/HL, HL wrap in both directions
  task automatic test_indirect_and_wrap();
    logic [7:0] p [] = '{8'h01, 8'h90, 8'h00, 8'h0A, 8'h21, 8'h00, 8'h00, 8'h32,
                         8'h22, 8'h11, 8'h91, 8'h00, 8'h1A, 8'h22, 8'h3A, 8'h32, 8'h00};
    hold_reset();
    load(p, 0);
    mem[8'h90] = 8'h5A;
    mem[8'h91] = 8'h3C;
    run(30);
    chk_bus("R7 read at BC", 4, 1, 0, 16'h0090);
    chk_bus("R7 two cycles then fetch", 5, 1, 0, 16'h0004);
    chk("R7 retire", 32'(tr_ret[5]), 1);
    chk_bus("R7 read at DE", 16, 1, 0, 16'h0091);
    chk_bus("R9 read at HL for 0x3A", 20, 1, 0, 16'h0001);
    chk_log("R9 store then dec wraps", 0, 16'h0000, 8'h5A);
    chk_log("R9 inc from FFFF", 1, 16'hFFFF, 8'h5A);
    chk_log("R7 R9 de load and wrap", 2, 16'h0000, 8'h3C);
    chk_log("R9 load with dec", 3, 16'h0000, 8'h90);
    chk("R11 fault after run", 32'(tr_ill[25]), 1);
  endtask

  // SP store across 0xFFFF and load through (HL)
  task automatic test_sp_store_and_hl_load();
    logic [7:0] p [] = '{8'h31, 8'h34, 8'h12, 8'h08, 8'hFF, 8'hFF, 8'h21, 8'hA0,
                         8'h00, 8'h4E, 8'h61, 8'h7C, 8'h22, 8'h00};
    hold_reset();
    load(p, 0);
    mem[8'hA0] = 8'h77;
    run(24);
    chk_bus("R10 read addr low", 4, 1, 0, 16'h0004);
    chk_bus("R10 read addr high", 5, 1, 0, 16'h0005);
    chk_bus("R10 write low byte", 6, 0, 1, 16'hFFFF);
    chk_bus("R10 write high byte wraps", 7, 0, 1, 16'h0000);
    chk("R3 retire on write cycle", 32'(tr_ret[7]), 1);
    chk_bus("R3 R4 fetch next cycle pc+3", 8, 1, 0, 16'h0006);
    chk_log("R10 sp low", 0, 16'hFFFF, 8'h34);
    chk_log("R10 sp high", 1, 16'h0000, 8'h12);
    chk_bus("R6 read at HL", 12, 1, 0, 16'h00A0);
    chk_bus("R6 second cycle fetch", 13, 1, 0, 16'h000A);
    chk_log("R6 R5 chain into HL", 2, 16'h77A0, 8'h77);
  endtask

  task automatic test_bad_opcode(input logic [7:0] op);
    string t;
    t = $sformatf("R11 op %0h", op);
    hold_reset();
    mem[0] = op;
    run(10);
    chk({t, " decode idle"}, 32'(tr_re[1] | tr_we[1]), 0);
    chk({t, " flag low"}, 32'(tr_ill[1]), 0);
    chk({t, " flag high"}, 32'(tr_ill[2]), 1);
    chk({t, " quiet"}, 32'(tr_re[6] | tr_we[6] | tr_ret[6]), 0);
  endtask

  // reset state: A, HL, SP all zero
  task automatic test_reset_state();
    logic [7:0] p [] = '{8'h22, 8'h08, 8'h40, 8'h00, 8'h00};
    hold_reset();
    load(p, 0);
    run(14);
    chk("R2 R11 flag cleared by reset", 32'(tr_ill[0]), 0);
    chk_bus("R2 first fetch", 0, 1, 0, 16'h0000);
    chk_log("R2 A and HL zero", 0, 16'h0000, 8'h00);
    chk_log("R2 SP low zero", 1, 16'h0040, 8'h00);
    chk_log("R2 SP high zero", 2, 16'h0041, 8'h00);
    chk_bus("R4 fetch after 0x08 at pc+3", 7, 1, 0, 16'h0004);
  endtask

  initial begin
    mem_rdata_i = '0;
    test_moves_and_fetch();
    test_indirect_and_wrap();
    test_sp_store_and_hl_load();
    test_bad_opcode(8'h76);
    test_bad_opcode(8'h70);
    test_bad_opcode(8'h02);
    test_reset_state();
    summary();
    $finish;
  end
endmodule